// File: doc/BRIEF.md
# External Bus Idle-State Sequencer

This block sequences cycles on an external memory bus. Each access request carries an area number, a direction flag, a flag that selects a three-state cycle, an address and write data. An external access runs as T1, T2 and, when requested, T3. The address is valid from T1 onward. The read or write strobe is asserted low in T2 and T3. For a write, the block drives the data bus in every active state.

Some devices are slow to release the data bus after a read. To keep such a device from colliding with the next device, the sequencer can place a single dead state, TI, in front of a cycle. It decides this from the previous cycle's direction and area.

Two bits of a small control register enable the two insertion conditions. The first applies to a read that follows a read to another area. The second applies to a write that follows a read. The sequencer only remembers the previous cycle when the new cycle starts directly after it. An internal access, or any quiet bus state, makes the next cycle start without history.

Top module: `busIdleInserter`

## Requirements
- R1: After reset the control register reads 2'b11 (bit 0 enables the different-area read condition, bit 1 enables the write-after-read condition). The bus is quiet after reset: idleFlag low, busRdN and busWrN high, busDataOe low.
- R2: With bit 0 set, a read that starts directly after a read to a different area is preceded by exactly one TI state.
- R3: With bit 1 set, a write that starts directly after a read is preceded by exactly one TI state.
- R4: During TI, idleFlag is high, busRdN and busWrN are high, busDataOe is low, and busAddr already shows the address of the coming cycle. idleFlag is low in every other state.
- R5: A read that starts directly after a read to the same area never gets a TI state, whatever the enable bits hold.
- R6: With bit 0 clear, reads to different areas run back to back, so a three-state read's T3 is followed directly by the next cycle's T1.
- R7: An access with reqExternal low produces no strobe and no data drive. The external access that follows it gets no TI state.
- R8: When at least one quiet bus state separates two external cycles, the second cycle gets no TI state.
- R9: Cycle shape. In T1 both strobes are negated and the address is valid. The strobe that matches the direction is low in T2, and also in T3 when reqThree was set. A write drives busDataOe high with busDataOut equal to the write data from T1 through its last state. A read never drives busDataOe.
- R10: reqAccept is high exactly when reqValid is high and the bus is either quiet or in the last state of a cycle.
- R11: A cycle that follows a write, whether a read or a write, gets no TI state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Write strobe for the control register |
| cfgWdata | input | 2 | New control register value |
| cfgRdata | output | 2 | Current control register value |
| reqValid | input | 1 | Access request present |
| reqExternal | input | 1 | Request targets external space |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqThree | input | 1 | Request a three-state cycle |
| reqArea | input | AREA_W | Address area number |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqAccept | output | 1 | Request taken at this clock edge |
| busAddr | output | ADDR_W | External address |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busDataOe | output | 1 | Data bus output enable |
| busDataOut | output | DATA_W | Data driven on writes |
| idleFlag | output | 1 | High during a TI state |

## Verification
The assertions assume that a requester holds its request steady until reqAccept rises. They also assume that reqArea and reqWrite are known whenever reqValid is high, since the insertion checks compare them with the latched cycle. The bench keeps to this rule: it changes request fields only away from the clock edge, and only after the previous request has been taken. The random stimulus mixes back-to-back requests, gaps, internal accesses and control register writes. Its area range is kept to four values so that same-area and different-area pairs both occur often.

// File: rtl/busIdlePkg.sv
package busIdlePkg;
  typedef enum logic [2:0] {
    S_QUIET = 3'd0,
    S_TI    = 3'd1,
    S_T1    = 3'd2,
    S_T2    = 3'd3,
    S_T3    = 3'd4
  } busState_e;

  typedef struct packed {
    logic load;
    logic idle;
    logic rdOn;
    logic wrOn;
    logic oeOn;
  } busCtl_t;
endpackage

// File: rtl/busIdleCtrl.sv
module busIdleCtrl
  import busIdlePkg::*;
#(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgWdata,
  output logic [1:0]        cfgRdata,
  input  logic              reqValid,
  input  logic              reqExternal,
  input  logic              reqWrite,
  input  logic [AREA_W-1:0] reqArea,
  input  logic [AREA_W-1:0] curArea,
  input  logic              curWrite,
  input  logic              curThree,
  output logic              reqAccept,
  output busCtl_t           ctl
);
  busState_e state, nextState;
  logic enDiffRead, enWriteAfterRead;
  logic lastState, canTake, needIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enDiffRead       <= 1'b1;
      enWriteAfterRead <= 1'b1;
    end else if (cfgWe) begin
      enDiffRead       <= cfgWdata[0];
      enWriteAfterRead <= cfgWdata[1];
    end
  end
  assign cfgRdata = {enWriteAfterRead, enDiffRead};

  always_comb begin
    lastState = (state == S_T3) || (state == S_T2 && !curThree);
    canTake   = (state == S_QUIET) || lastState;
    reqAccept = reqValid && canTake;
    needIdle  = lastState && !curWrite &&
                ((enDiffRead && !reqWrite && (reqArea != curArea)) ||
                 (enWriteAfterRead && reqWrite));
  end

  always_comb begin
    nextState = S_QUIET;
    if (reqAccept) begin
      if (reqExternal) nextState = needIdle ? S_TI : S_T1;
      else             nextState = S_QUIET;
    end else begin
      unique case (state)
        S_TI:    nextState = S_T1;
        S_T1:    nextState = S_T2;
        S_T2:    nextState = curThree ? S_T3 : S_QUIET;
        default: nextState = S_QUIET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_QUIET;
    else       state <= nextState;
  end

  always_comb begin
    ctl.load = reqAccept && reqExternal;
    ctl.idle = (state == S_TI);
    ctl.rdOn = (state == S_T2 || state == S_T3) && !curWrite;
    ctl.wrOn = (state == S_T2 || state == S_T3) && curWrite;
    ctl.oeOn = (state == S_T1 || state == S_T2 || state == S_T3) && curWrite;
  end

  // R2: a dead state always hands over to T1
  p_ti_then_t1_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == S_TI |=> state == S_T1);

  // R10: requests are taken only in a quiet or final state
  p_accept_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> (state == S_QUIET || state == S_T3 || (state == S_T2 && !curThree)));

  // R5: same-area read after read never gets a dead state
  p_same_area_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && reqExternal && !reqWrite && state != S_QUIET && !curWrite &&
     reqArea == curArea) |=> state != S_TI);

  // R8: starting from a quiet bus never inserts
  p_quiet_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && state == S_QUIET) |=> state != S_TI);

  // R11: nothing after a write is delayed
  p_after_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && state != S_QUIET && curWrite) |=> state != S_TI);
endmodule

// File: rtl/busIdleDp.sv
module busIdleDp
  import busIdlePkg::*;
#(
  parameter int AREA_W = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic              reqWrite,
  input  logic              reqThree,
  input  logic [AREA_W-1:0] reqArea,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [AREA_W-1:0] curArea,
  output logic              curWrite,
  output logic              curThree,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic              idleFlag
);
  logic [DATA_W-1:0] holdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curArea  <= '0;
      curWrite <= 1'b0;
      curThree <= 1'b0;
      busAddr  <= '0;
      holdData <= '0;
    end else if (ctl.load) begin
      curArea  <= reqArea;
      curWrite <= reqWrite;
      curThree <= reqThree;
      busAddr  <= reqAddr;
      holdData <= reqWdata;
    end
  end

  always_comb begin
    busRdN     = !ctl.rdOn;
    busWrN     = !ctl.wrOn;
    busDataOe  = ctl.oeOn;
    busDataOut = ctl.oeOn ? holdData : '0;
    idleFlag   = ctl.idle;
  end

  // R4: the dead state is fully quiet on strobes and data
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    idleFlag |-> (busRdN && busWrN && !busDataOe));

  // R9: a read strobe never overlaps a data drive
  p_read_no_drive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busDataOe);

  // R9: the two strobes are never low together
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdN || busWrN);
endmodule

// File: rtl/busIdleInserter.sv
module busIdleInserter
  import busIdlePkg::*;
#(
  parameter int AREA_W = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgWdata,
  output logic [1:0]        cfgRdata,
  input  logic              reqValid,
  input  logic              reqExternal,
  input  logic              reqWrite,
  input  logic              reqThree,
  input  logic [AREA_W-1:0] reqArea,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAccept,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic              idleFlag
);
  busCtl_t ctl;
  logic [AREA_W-1:0] curArea;
  logic curWrite, curThree;

  busIdleCtrl #(.AREA_W(AREA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqExternal(reqExternal), .reqWrite(reqWrite),
    .reqArea(reqArea), .curArea(curArea), .curWrite(curWrite),
    .curThree(curThree), .reqAccept(reqAccept), .ctl(ctl)
  );

  busIdleDp #(.AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqThree(reqThree), .reqArea(reqArea),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .curArea(curArea), .curWrite(curWrite), .curThree(curThree),
    .busAddr(busAddr), .busRdN(busRdN), .busWrN(busWrN),
    .busDataOe(busDataOe), .busDataOut(busDataOut), .idleFlag(idleFlag)
  );
endmodule

// File: tb/sim_busIdleInserter.sv
module sim_busIdleInserter;
  localparam int AW = 3, DW = 16, XW = 16;
  logic clk = 0, rstN = 0;
  logic cfgWe = 0; logic [1:0] cfgWdata = 0; logic [1:0] cfgRdata;
  logic reqValid = 0, reqExternal = 0, reqWrite = 0, reqThree = 0;
  logic [AW-1:0] reqArea = 0; logic [XW-1:0] reqAddr = 0; logic [DW-1:0] reqWdata = 0;
  logic reqAccept, busRdN, busWrN, busDataOe, idleFlag;
  logic [XW-1:0] busAddr; logic [DW-1:0] busDataOut;

  always #10 clk = ~clk;

  busIdleInserter #(.AREA_W(AW), .ADDR_W(XW), .DATA_W(DW)) u0 (.*);

  int nChk = 0, nFail = 0, idleSeen = 0;
  bit done = 0;
  // model: 0 quiet, 1 TI, 2 T1, 3 T2, 4 T3
  int ms = 0;
  logic [AW-1:0] mArea = 0; bit mWrite = 0, mThree = 0;
  logic [XW-1:0] mAddr = 0; logic [DW-1:0] mData = 0;
  bit mEnDiff = 1, mEnWar = 1;
  bit pV = 0, pExt = 0, pW = 0, pT = 0; logic [AW-1:0] pA = 0;
  logic [XW-1:0] pAd = 0; logic [DW-1:0] pD = 0;
  bit cWe = 0; logic [1:0] cWd = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit lastSt();
    return (ms == 3 && !mThree) || ms == 4;
  endfunction

  function automatic bit needIdle();
    return lastSt() && !mWrite &&
           ((mEnDiff && !pW && pA != mArea) || (mEnWar && pW));
  endfunction

  task automatic tick();
    bit acc;
    // outputs against model
    chk("R4 idleFlag", idleFlag, ms == 1);
    chk("R9 busRdN", busRdN, !((ms == 3 || ms == 4) && !mWrite));
    chk("R9 busWrN", busWrN, !((ms == 3 || ms == 4) && mWrite));
    chk("R9 busDataOe", busDataOe, (ms >= 2) && mWrite);
    if (ms != 0) chk("R4 busAddr", busAddr, mAddr);
    if (ms >= 2 && mWrite) chk("R9 busDataOut", busDataOut, mData);
    if (idleFlag) idleSeen++;
    reqValid = pV; reqExternal = pExt; reqWrite = pW; reqThree = pT;
    reqArea = pA; reqAddr = pAd; reqWdata = pD;
    cfgWe = cWe; cfgWdata = cWd;
    #1;
    acc = pV && (ms == 0 || lastSt());
    chk("R10 reqAccept", reqAccept, acc);
    if (acc) begin
      if (pExt) begin
        ms = needIdle() ? 1 : 2;
        mArea = pA; mWrite = pW; mThree = pT; mAddr = pAd; mData = pD;
      end else ms = 0;
      pV = 0;
    end else begin
      case (ms)
        1: ms = 2;
        2: ms = 3;
        3: ms = mThree ? 4 : 0;
        default: ms = 0;
      endcase
    end
    if (cWe) begin mEnDiff = cWd[0]; mEnWar = cWd[1]; end
    cWe = 0;
    @(negedge clk);
  endtask

  task automatic send(bit ext, bit w, bit t, logic [AW-1:0] a);
    pV = 1; pExt = ext; pW = w; pT = t; pA = a;
    pAd = XW'($urandom); pD = DW'($urandom);
    while (pV) tick();
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain();
    while (ms != 0) tick();
    tick();
  endtask

  task automatic setCfg(logic [1:0] v);
    cWe = 1; cWd = v; tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5EED1D1E));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfgRdata", cfgRdata, 2'b11);
    chk("R1 idleFlag", idleFlag, 0);
    chk("R1 busRdN", busRdN, 1);
    chk("R1 busWrN", busWrN, 1);
    chk("R1 busDataOe", busDataOe, 0);

    // R2 different-area reads back to back
    base = idleSeen; send(1,0,1,3'd1); send(1,0,0,3'd2); drain();
    chk("R2 idle count", idleSeen - base, 1);
    // R5 same-area reads
    base = idleSeen; send(1,0,0,3'd2); send(1,0,1,3'd2); drain();
    chk("R5 idle count", idleSeen - base, 0);
    // R3 write after read
    base = idleSeen; send(1,0,0,3'd4); send(1,1,0,3'd4); drain();
    chk("R3 idle count", idleSeen - base, 1);
    // R11 read and write after write
    base = idleSeen; send(1,1,0,3'd1); send(1,0,0,3'd5); drain();
    send(1,1,1,3'd1); send(1,1,0,3'd6); drain();
    chk("R11 idle count", idleSeen - base, 0);
    // R7 internal access between reads
    base = idleSeen; send(1,0,0,3'd1); send(0,0,0,3'd0); send(1,0,0,3'd3); drain();
    chk("R7 idle count", idleSeen - base, 0);
    // R8 one quiet state between reads
    base = idleSeen; send(1,0,0,3'd1); quiet(3); send(1,0,0,3'd3); drain();
    chk("R8 idle count", idleSeen - base, 0);
    // R6 enable off: T3 straight into T1
    setCfg(2'b10);
    chk("R6 cfgRdata", cfgRdata, 2'b10);
    base = idleSeen; send(1,0,1,3'd1); send(1,0,0,3'd2);
    chk("R6 next is T1 idle", idleFlag, 0);
    chk("R6 next is T1 addr", busAddr, pAd);
    drain();
    chk("R6 idle count", idleSeen - base, 0);
    // R5 same area with everything on or off
    base = idleSeen; send(1,0,0,3'd7); send(1,0,0,3'd7); drain();
    chk("R5 idle count off", idleSeen - base, 0);
    setCfg(2'b11);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) setCfg(2'($urandom));
      else if (r < 12) quiet($urandom_range(1, 2));
      else send($urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0,
                1'($urandom), AW'($urandom_range(0, 3)));
    end
    drain();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule